// File: doc/BRIEF.md
# Register-Driven Multiply-Accumulate Unit

This block is a 16x16 fixed-point multiplier feeding a 48-bit accumulator, driven entirely through a small register write port. Software first writes a control register to choose the operation and the trigger style. It then loads the operand registers. The write that supplies the final operand launches the operation in the same clock edge, so the updated accumulator appears on the outputs one cycle later. A new operation can be launched on every cycle.

Seven operations are available: unsigned multiply, multiply-add and multiply-subtract, and signed multiply, multiply-negate, multiply-add and multiply-subtract. Plain multiply and multiply-negate overwrite the accumulator. The add and subtract forms fold the product into the running total. A square mode takes a single operand and uses it as both factors. A sticky flag records when an add or subtract leaves the 48-bit range for the selected signedness. The accumulator is presented as three 16-bit words, and the control state can be read back alongside them.

Top module: `mac16_unit`

## Requirements
- R1: After reset, all three accumulator words read zero and `ctrl_rd` reads zero.
- R2: A write to address 0 stores the configuration, and `ctrl_rd[4:0]` reflects it on the next cycle with `ctrl_rd[6:5]` reading 0. The configuration fields are: bits 2:0 select the operation (0 unsigned multiply, 1 unsigned add-product, 2 unsigned subtract-product, 3 signed multiply, 4 signed negated multiply, 5 signed add-product, 6 signed subtract-product, 7 reserved); bit 3 selects square mode; bit 4 selects either-operand trigger.
- R3: In two-operand mode, a write to operand B (address 2) launches the operation. It uses the stored operand A (address 1) and the newly written B, and the result is visible on the accumulator words in the next cycle.
- R4: Unsigned multiply loads the zero-extended product into the accumulator. Signed multiply loads the sign-extended product. Signed negated multiply loads the two's-complement negation of the signed product.
- R5: The add and subtract operations add the product to, or subtract it from, the accumulator, modulo 2^48. The unsigned forms treat both the product and the accumulator as unsigned. The signed forms treat both as two's complement.
- R6: In two-operand mode with bit 4 clear, a write to operand A leaves the accumulator unchanged. With bit 4 set, a write to A launches the operation using the new A and the stored B.
- R7: In square mode, a write to A launches the operation with A as both factors. A write to B only stores B and changes neither the accumulator nor the flag.
- R8: With operation code 7, operand writes change neither the accumulator nor the overflow flag.
- R9: `ctrl_rd[7]` is set when an add or subtract result falls outside 0..2^48-1 (unsigned) or -2^47..2^47-1 (signed). Once set, it stays set through later operations, including plain multiplies.
- R10: A control write clears state according to three bits: bit 7 set clears the overflow flag; bit 6 set zeroes the accumulator; bit 5 set zeroes both operand registers. None of these three bits is stored.
- R11: Launches on consecutive cycles each take effect, with no wait state between them.
- R12: `acc_w0` carries accumulator bits 15:0, `acc_w1` bits 31:16 and `acc_w2` bits 47:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 operand A, 2 operand B |
| wr_data | input | 16 | Write data |
| acc_w0 | output | 16 | Accumulator bits 15:0 |
| acc_w1 | output | 16 | Accumulator bits 31:16 |
| acc_w2 | output | 16 | Accumulator bits 47:32 |
| ctrl_rd | output | 8 | Control readback: overflow flag in bit 7, configuration in bits 4:0 |

## Verification
The properties assume that at most one register is written per cycle and that only the addresses 0 to 2 are written. An address outside that set is taken to have no effect. The bench drives one write per cycle, with addresses drawn from those three values. It mixes random control values, including random clear bits and the reserved code, with random operands. Directed cases cover the extreme operands, wrap below zero, a long run of additions that crosses the signed upper limit, and the clear controls.

// File: rtl/mac_pkg.sv
package mac_pkg;

    parameter int DATA_W    = 16;
    parameter int ACC_W     = 48;
    parameter int ADDR_W    = 3;
    parameter int CTRL_W    = 8;
    localparam int PROD_W   = 2 * (DATA_W + 1);
    localparam int SUM_W    = ACC_W + 2;
    localparam int ACC_WORDS = ACC_W / DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_OPA = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_OPB = 3'd2;

    // Bit positions inside a control write
    localparam int BIT_CLR_OPND = 5;
    localparam int BIT_CLR_ACC  = 6;
    localparam int BIT_CLR_OVF  = 7;

    typedef enum logic [2:0] {
        OP_UMUL = 3'd0,
        OP_UMAC = 3'd1,
        OP_UMSU = 3'd2,
        OP_SMUL = 3'd3,
        OP_SNEG = 3'd4,
        OP_SMAC = 3'd5,
        OP_SMSU = 3'd6,
        OP_RSVD = 3'd7
    } mac_op_e;

    typedef struct packed {
        logic    trig_any;
        logic    square;
        mac_op_e op;
    } mac_cfg_t;

    typedef struct packed {
        logic              fire;
        logic              sgn;
        logic              accu;
        logic              sub;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
    } mac_issue_t;

    function automatic logic op_is_signed(mac_op_e op);
        return op inside {OP_SMUL, OP_SNEG, OP_SMAC, OP_SMSU};
    endfunction

    function automatic logic op_accumulates(mac_op_e op);
        return op inside {OP_UMAC, OP_UMSU, OP_SMAC, OP_SMSU};
    endfunction

    function automatic logic op_subtracts(mac_op_e op);
        return op inside {OP_UMSU, OP_SNEG, OP_SMSU};
    endfunction

    function automatic logic op_legal(mac_op_e op);
        return op != OP_RSVD;
    endfunction

endpackage

// File: rtl/mac_regs.sv
module mac_regs
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mac_cfg_t          cfg,
    output mac_issue_t        issue,
    output logic              clr_acc,
    output logic              clr_ovf
);

    mac_cfg_t          cfg_q;
    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] opb_q;
    logic              wr_cfg;
    logic              wr_a;
    logic              wr_b;

    assign wr_cfg = wr_en && (wr_addr == ADDR_CFG);
    assign wr_a   = wr_en && (wr_addr == ADDR_OPA);
    assign wr_b   = wr_en && (wr_addr == ADDR_OPB);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_q <= mac_cfg_t'(wr_data[$bits(mac_cfg_t)-1:0]);
                if (wr_data[BIT_CLR_OPND]) begin
                    opa_q <= '0;
                    opb_q <= '0;
                end
            end
            if (wr_a) opa_q <= wr_data;
            if (wr_b) opb_q <= wr_data;
        end
    end

    // Launch decode: the final operand write fires, using the incoming data
    always_comb begin
        issue      = '0;
        issue.sgn  = op_is_signed(cfg_q.op);
        issue.accu = op_accumulates(cfg_q.op);
        issue.sub  = op_subtracts(cfg_q.op);
        if (op_legal(cfg_q.op)) begin
            if (cfg_q.square) begin
                if (wr_a) begin
                    issue.fire = 1'b1;
                    issue.x    = wr_data;
                    issue.y    = wr_data;
                end
            end else if (wr_b) begin
                issue.fire = 1'b1;
                issue.x    = opa_q;
                issue.y    = wr_data;
            end else if (wr_a && cfg_q.trig_any) begin
                issue.fire = 1'b1;
                issue.x    = wr_data;
                issue.y    = opb_q;
            end
        end
    end

    assign cfg     = cfg_q;
    assign clr_acc = wr_cfg && wr_data[BIT_CLR_ACC];
    assign clr_ovf = wr_cfg && wr_data[BIT_CLR_OVF];

endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
(
    input  logic              sgn,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [PROD_W-1:0] prod
);

    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0]  x_ext;
    logic signed [EXT_W-1:0]  y_ext;
    logic signed [PROD_W-1:0] p;

    // One extra bit lets a single signed multiplier serve both data types
    assign x_ext = {sgn & x[DATA_W-1], x};
    assign y_ext = {sgn & y[DATA_W-1], y};
    assign p     = x_ext * y_ext;
    assign prod  = p;

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              sgn,
    input  logic              accu,
    input  logic              sub,
    input  logic [PROD_W-1:0] prod,
    input  logic              clr_acc,
    input  logic              clr_ovf,
    output logic [ACC_W-1:0]  acc,
    output logic              ovf
);

    logic [ACC_W-1:0] acc_q;
    logic             ovf_q;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] term;
    logic [SUM_W-1:0] sum;
    logic             out_of_range;

    assign base = accu ? {{(SUM_W-ACC_W){sgn & acc_q[ACC_W-1]}}, acc_q} : '0;
    assign term = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign sum  = sub ? (base - term) : (base + term);

    // Guard bits must agree with the result's top bit (signed) or be zero (unsigned)
    always_comb begin
        if (sgn)
            out_of_range = !((sum[SUM_W-1:ACC_W-1] == '0) || (sum[SUM_W-1:ACC_W-1] == '1));
        else
            out_of_range = (sum[SUM_W-1:ACC_W] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (clr_acc)
                acc_q <= '0;
            else if (fire)
                acc_q <= sum[ACC_W-1:0];
            if (clr_ovf)
                ovf_q <= 1'b0;
            else if (fire && accu && out_of_range)
                ovf_q <= 1'b1;
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_w0,
    output logic [DATA_W-1:0] acc_w1,
    output logic [DATA_W-1:0] acc_w2,
    output logic [CTRL_W-1:0] ctrl_rd
);

    mac_cfg_t          cfg;
    mac_issue_t        issue;
    logic              clr_acc;
    logic              clr_ovf;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;
    logic              ovf;
    logic [DATA_W-1:0] words [ACC_WORDS];

    mac_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .issue   (issue),
        .clr_acc (clr_acc),
        .clr_ovf (clr_ovf)
    );

    mac_mult i_mult (
        .sgn  (issue.sgn),
        .x    (issue.x),
        .y    (issue.y),
        .prod (prod)
    );

    mac_accum i_accum (
        .clk     (clk),
        .rst     (rst),
        .fire    (issue.fire),
        .sgn     (issue.sgn),
        .accu    (issue.accu),
        .sub     (issue.sub),
        .prod    (prod),
        .clr_acc (clr_acc),
        .clr_ovf (clr_ovf),
        .acc     (acc),
        .ovf     (ovf)
    );

    for (genvar w = 0; w < ACC_WORDS; w++) begin : g_word
        assign words[w] = acc[w*DATA_W +: DATA_W];
    end

    assign acc_w0  = words[0];
    assign acc_w1  = words[1];
    assign acc_w2  = words[2];
    assign ctrl_rd = {ovf, {(CTRL_W-1-$bits(mac_cfg_t)){1'b0}}, cfg};

endmodule

// File: rtl/mac16_checker.sv
module mac16_checker
    import mac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ACC_W-1:0]  acc,
    input logic [CTRL_W-1:0] ctrl_rd
);

    logic cfg_wr;
    logic opnd_wr;
    assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
    assign opnd_wr = wr_en && (wr_addr != ADDR_CFG);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(acc) && $stable(ctrl_rd)));

    a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (opnd_wr && ctrl_rd[2:0] == 3'd7) |=> ($stable(acc) && $stable(ctrl_rd[7])));

    a_r7_square_b_store_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_OPB && ctrl_rd[3]) |=> ($stable(acc) && $stable(ctrl_rd[7])));

    a_r9_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd[7] && !(cfg_wr && wr_data[BIT_CLR_OVF])) |=> ctrl_rd[7]);

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && wr_data[BIT_CLR_OVF]) |=> !ctrl_rd[7]);

    a_r10_acc_clear: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && wr_data[BIT_CLR_ACC]) |=> (acc == '0));

    a_r2_cfg_readback: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (ctrl_rd[4:0] == $past(wr_data[4:0]) && ctrl_rd[6:5] == 2'b00));

endmodule

bind mac16_unit mac16_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .acc     ({acc_w2, acc_w1, acc_w0}),
    .ctrl_rd (ctrl_rd)
);

// File: tb/test_mac16_unit.sv
module test_mac16_unit;
    import mac_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] acc_w0, acc_w1, acc_w2;
    logic [7:0]  ctrl_rd;

    mac16_unit i_mac16_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_w0(acc_w0), .acc_w1(acc_w1), .acc_w2(acc_w2), .ctrl_rd(ctrl_rd)
    );

    always #10 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [4:0]  m_cfg;
    logic [15:0] m_a, m_b;
    logic [47:0] m_acc;
    logic        m_ovf;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] acc_now();
        return {acc_w2, acc_w1, acc_w0};
    endfunction

    task automatic m_exec(logic [15:0] x, logic [15:0] y);
        logic [2:0] op;
        bit sg, accu, sub;
        longint xs, ys, p, base, r, lim;
        op   = m_cfg[2:0];
        sg   = (op >= 3'd3 && op <= 3'd6);
        accu = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
        sub  = (op == 3'd2 || op == 3'd4 || op == 3'd6);
        xs   = sg ? longint'($signed(x)) : longint'(x);
        ys   = sg ? longint'($signed(y)) : longint'(y);
        p    = xs * ys;
        base = 0;
        if (accu) base = sg ? longint'($signed(m_acc)) : longint'(m_acc);
        r    = sub ? base - p : base + p;
        lim  = longint'(1) << 47;
        if (accu) begin
            if (sg && (r > lim - 1 || r < -lim)) m_ovf = 1'b1;
            if (!sg && (r < 0 || r > 2 * lim - 1)) m_ovf = 1'b1;
        end
        m_acc = r[47:0];
    endtask

    task automatic m_step(logic [2:0] a, logic [15:0] d);
        bit legal;
        legal = (m_cfg[2:0] != 3'd7);
        if (a == 3'd0) begin
            m_cfg = d[4:0];
            if (d[5]) begin m_a = '0; m_b = '0; end
            if (d[6]) m_acc = '0;
            if (d[7]) m_ovf = 1'b0;
        end else if (a == 3'd1) begin
            m_a = d;
            if (legal && m_cfg[3]) m_exec(d, d);
            else if (legal && m_cfg[4]) m_exec(d, m_b);
        end else if (a == 3'd2) begin
            m_b = d;
            if (legal && !m_cfg[3]) m_exec(m_a, d);
        end
    endtask

    task automatic do_wr(logic [2:0] a, logic [15:0] d, string tag);
        m_step(a, d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
        check(acc_now() == m_acc, tag, 64'(acc_now()), 64'(m_acc));
        check(ctrl_rd == {m_ovf, 2'b00, m_cfg}, tag, 64'(ctrl_rd), 64'({m_ovf, 2'b00, m_cfg}));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_cfg = '0; m_a = '0; m_b = '0; m_acc = '0; m_ovf = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        check(acc_now() == 48'd0, "R1", 64'(acc_now()), 64'd0);
        check(ctrl_rd == 8'd0, "R1", 64'(ctrl_rd), 64'd0);

        // R2 configuration, R6 A write alone, R3 B write launches
        do_wr(3'd0, 16'h0000, "R2");
        do_wr(3'd1, 16'hFFFF, "R6");
        check(acc_now() == 48'd0, "R6", 64'(acc_now()), 64'd0);
        do_wr(3'd2, 16'hFFFF, "R3");
        check(acc_now() == 48'h0000_FFFE_0001, "R4", 64'(acc_now()), 64'h0000_FFFE_0001);
        check(acc_w0 == 16'h0001 && acc_w1 == 16'hFFFE && acc_w2 == 16'h0000, "R12",
              64'(acc_now()), 64'h0000_FFFE_0001);

        // R4 signed multiply and negate
        do_wr(3'd0, 16'h0003, "R2");
        do_wr(3'd2, 16'h8000, "R4");
        check(acc_now() == 48'h0000_0000_8000, "R4", 64'(acc_now()), 64'h8000);
        do_wr(3'd1, 16'h8000, "R4");
        do_wr(3'd2, 16'h8000, "R4");
        check(acc_now() == 48'h0000_4000_0000, "R4", 64'(acc_now()), 64'h4000_0000);
        do_wr(3'd0, 16'h0004, "R2");
        do_wr(3'd1, 16'h0003, "R4");
        do_wr(3'd2, 16'h0005, "R4");
        check(acc_now() == 48'hFFFF_FFFF_FFF1, "R4", 64'(acc_now()), 64'hFFFF_FFFF_FFF1);

        // R10 accumulator clear, R9 unsigned wrap below zero
        do_wr(3'd0, 16'h0042, "R10");
        check(acc_now() == 48'd0, "R10", 64'(acc_now()), 64'd0);
        do_wr(3'd1, 16'h0001, "R5");
        do_wr(3'd2, 16'h0001, "R9");
        check(ctrl_rd[7] == 1'b1, "R9", 64'(ctrl_rd[7]), 64'd1);
        check(acc_w2 == 16'hFFFF, "R12", 64'(acc_w2), 64'hFFFF);
        do_wr(3'd0, 16'h0000, "R9");
        do_wr(3'd2, 16'h0002, "R9");
        check(ctrl_rd[7] == 1'b1, "R9", 64'(ctrl_rd[7]), 64'd1);
        do_wr(3'd0, 16'h0080, "R10");
        check(ctrl_rd[7] == 1'b0, "R10", 64'(ctrl_rd[7]), 64'd0);

        // R7 square mode
        do_wr(3'd0, 16'h000B, "R2");
        do_wr(3'd1, 16'hFFFE, "R7");
        check(acc_now() == 48'd4, "R7", 64'(acc_now()), 64'd4);
        do_wr(3'd2, 16'h1234, "R7");
        check(acc_now() == 48'd4, "R7", 64'(acc_now()), 64'd4);

        // R6 either-operand trigger
        do_wr(3'd0, 16'h0010, "R2");
        do_wr(3'd1, 16'h0002, "R6");
        check(acc_now() == 48'h2468, "R6", 64'(acc_now()), 64'h2468);

        // R8 reserved code
        do_wr(3'd0, 16'h0017, "R2");
        do_wr(3'd2, 16'h0005, "R8");
        do_wr(3'd1, 16'h0007, "R8");
        check(acc_now() == 48'h2468, "R8", 64'(acc_now()), 64'h2468);

        // R10 operand clear
        do_wr(3'd0, 16'h0021, "R10");
        do_wr(3'd2, 16'h0007, "R10");
        check(acc_now() == 48'h2468, "R10", 64'(acc_now()), 64'h2468);

        // R5 signed subtract and add
        do_wr(3'd0, 16'h0046, "R5");
        do_wr(3'd1, 16'h0010, "R5");
        do_wr(3'd2, 16'hFFFF, "R5");
        check(acc_now() == 48'd16, "R5", 64'(acc_now()), 64'd16);
        do_wr(3'd0, 16'h0005, "R5");
        do_wr(3'd2, 16'hFFF0, "R5");
        check(acc_now() == 48'hFFFF_FFFF_FF10, "R5", 64'(acc_now()), 64'hFFFF_FFFF_FF10);

        // R11 long back-to-back run, then R9 signed upper limit crossed
        do_wr(3'd0, 16'h00C1, "R10");
        do_wr(3'd1, 16'hFFFF, "R11");
        for (int i = 0; i < 32769; i++) do_wr(3'd2, 16'hFFFF, "R11");
        check(acc_now() == 48'h7FFF_FFFE_8001, "R11", 64'(acc_now()), 64'h7FFF_FFFE_8001);
        check(ctrl_rd[7] == 1'b0, "R9", 64'(ctrl_rd[7]), 64'd0);
        do_wr(3'd0, 16'h0005, "R2");
        do_wr(3'd1, 16'h7FFF, "R5");
        do_wr(3'd2, 16'h7FFF, "R9");
        check(acc_now() == 48'h8000_3FFD_8002, "R5", 64'(acc_now()), 64'h8000_3FFD_8002);
        check(ctrl_rd[7] == 1'b1, "R9", 64'(ctrl_rd[7]), 64'd1);

        // R11 random back-to-back traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  a;
            logic [15:0] d;
            a = ($urandom % 6 == 0) ? 3'd0 : 3'd1 + 3'($urandom % 2);
            d = 16'($urandom);
            if (a == 3'd0 && ($urandom % 4 != 0)) d[6] = 1'b0;
            do_wr(a, d, "R11");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule